// File: doc/BRIEF.md
# Run-Time Depth-Selectable Arithmetic Pipeline

This block pushes 16-bit words through a fixed chain of four short arithmetic steps: add, exclusive-or, rotate and add. A register follows each step. The registers behind the first and third steps can each be bypassed. A multiplexer then forwards that register's live input instead of the copy held in its flip-flop. This lets one datapath run either as a four-register pipeline, suited to a fast clock, or as a two-register pipeline, suited to a clock at half the rate. The result is the same in both cases, and so is the wall-clock completion time.

The stream interface is a valid-qualified word in each direction. There is no ready signal and no back-pressure: the block takes one word on every clock where `in_valid` is high, in either depth. It delivers results in arrival order, and the consumer must take each word in the cycle it is presented. A request for the other depth is held back while any word is in flight. It is also held back in any cycle where a new word arrives. `busy` reports that a request is waiting, so the producer can pause its input and let the chain drain.

Top module: `rdp_pipe`

## Requirements
- R1: While reset is asserted and right after it is released, `out_valid` is 0, `busy` is 0, and `mode_shallow` is 0, which means the deep depth.
- R2: Every result equals ((((x + 16'h3A5C) ^ 16'hC3A5) rotated left by one bit) + 16'h1234) mod 2^16, where x is the input word. This holds in both depths.
- R3: In deep depth (`mode_shallow` = 0), a word captured at clock edge n appears with `out_valid` high after edge n+3. That is four register stages of latency.
- R4: In shallow depth (`mode_shallow` = 1), a word captured at clock edge n appears after edge n+1. That is two register stages of latency, half the deep figure.
- R5: A word is accepted on every edge where `in_valid` is 1, with no gaps required. Results leave in the same order as the inputs, one per cycle for back-to-back input.
- R6: `mode_sel` = 1 requests shallow depth and `mode_sel` = 0 requests deep depth. A change takes effect only at an edge where no word is in flight and `in_valid` is 0. `mode_shallow` shows the depth in force.
- R7: `busy` is 1 exactly when `mode_sel` differs from the depth in force.
- R8: `out_valid` is never raised for a word that was not supplied, including right after a depth change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Requested depth: 1 shallow, 0 deep |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 16 | Input word |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 16 | Result word |
| busy | output | 1 | A depth change is requested but not yet applied |
| mode_shallow | output | 1 | Depth in force: 1 shallow, 0 deep |

## Verification
Back-to-back streams in each depth test the latency counts and in-order delivery. Streams with gaps show that no result is produced for an empty slot. Corner words (0, all ones, and values with only the top or only the bottom bit set) go through the rotate and carry paths. Each of them is sent in both depths to show the result does not depend on depth. Depth requests are made while words are in flight, and also while input keeps arriving on an otherwise empty chain, to show that the switch waits and `busy` tracks the wait. Toggling the depth across a long pseudo-random stream then looks for phantom or lost results around each switch.

// File: rtl/rdp_pkg.sv
package rdp_pkg;
  // Constants for the arithmetic steps (truncated or extended to the datapath width)
  localparam logic [31:0] ADD_A = 32'h0000_3A5C;
  localparam logic [31:0] XOR_B = 32'h0000_C3A5;
  localparam logic [31:0] ADD_C = 32'h0000_1234;

  typedef enum logic {
    DEPTH_DEEP    = 1'b0,
    DEPTH_SHALLOW = 1'b1
  } depth_e;
endpackage

// File: rtl/rdp_stage.sv
// One short combinational step; the operation is chosen by the stage index.
module rdp_stage #(
  parameter int W   = 16,
  parameter int IDX = 0
) (
  input  logic [W-1:0] d,
  output logic [W-1:0] y
);
  import rdp_pkg::*;

  localparam int OPSEL = IDX % 4;

  generate
    if (OPSEL == 0) begin : g_add_a
      assign y = d + W'(ADD_A);
    end else if (OPSEL == 1) begin : g_xor_b
      assign y = d ^ W'(XOR_B);
    end else if (OPSEL == 2) begin : g_rotl
      assign y = {d[W-2:0], d[W-1]};
    end else begin : g_add_c
      assign y = d + W'(ADD_C);
    end
  endgenerate
endmodule

// File: rtl/rdp_slot.sv
// Stage register with an optional pass-through. When byp is high the live input
// is forwarded and the stored valid is forced low so nothing stale remains.
module rdp_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         byp,
  input  logic [W-1:0] d,
  input  logic         d_valid,
  output logic [W-1:0] q,
  output logic         q_valid,
  output logic         held_valid
);
  logic [W-1:0] data_r;
  logic         vld_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= '0;
      vld_r  <= 1'b0;
    end else begin
      data_r <= d;
      vld_r  <= d_valid & ~byp;
    end
  end

  assign q          = byp ? d : data_r;
  assign q_valid    = byp ? d_valid : vld_r;
  assign held_valid = vld_r;
endmodule

// File: rtl/rdp_mode_ctrl.sv
// Holds the depth in force; applies a new request only on an empty, idle edge.
module rdp_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic in_valid,
  input  logic chain_empty,
  output logic shallow,
  output logic busy
);
  import rdp_pkg::*;

  depth_e depth_q;
  logic   apply;

  assign busy  = (mode_sel != depth_q);
  assign apply = busy & chain_empty & ~in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= DEPTH_DEEP;
    else if (apply) depth_q <= depth_e'(mode_sel);
  end

  assign shallow = (depth_q == DEPTH_SHALLOW);

  // R6: the depth only moves on an edge that saw an empty chain and no input
  a_r6_switch_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (shallow != $past(shallow)) |-> $past(chain_empty && !in_valid));

  // R6: a pending request waits while words are in flight or arriving
  a_r6_hold_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != shallow && (!chain_empty || in_valid)) |=> (shallow == $past(shallow)));
endmodule

// File: rtl/rdp_pipe.sv
module rdp_pipe #(
  parameter int W        = 16,
  parameter int N_STAGES = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_sel,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         busy,
  output logic         mode_shallow
);
  localparam int LAT_DEEP    = N_STAGES;
  localparam int LAT_SHALLOW = N_STAGES / 2;

  logic [W-1:0]        lane_d [0:N_STAGES];
  logic [N_STAGES:0]   lane_v;
  logic [W-1:0]        comb_d [0:N_STAGES-1];
  logic [N_STAGES-1:0] held_v;
  logic [N_STAGES-1:0] byp;
  logic                shallow;
  logic                chain_empty;

  assign lane_d[0] = in_data;
  assign lane_v[0] = in_valid;

  genvar k;
  generate
    for (k = 0; k < N_STAGES; k++) begin : g_step
      rdp_stage #(.W(W), .IDX(k)) u_stage (
        .d (lane_d[k]),
        .y (comb_d[k])
      );

      if (k % 2 == 0) begin : g_bypassable
        assign byp[k] = shallow;
      end else begin : g_fixed
        assign byp[k] = 1'b0;
      end

      rdp_slot #(.W(W)) u_slot (
        .clk        (clk),
        .rst_n      (rst_n),
        .byp        (byp[k]),
        .d          (comb_d[k]),
        .d_valid    (lane_v[k]),
        .q          (lane_d[k+1]),
        .q_valid    (lane_v[k+1]),
        .held_valid (held_v[k])
      );
    end
  endgenerate

  assign chain_empty = ~|held_v;

  rdp_mode_ctrl u_mode (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_sel    (mode_sel),
    .in_valid    (in_valid),
    .chain_empty (chain_empty),
    .shallow     (shallow),
    .busy        (busy)
  );

  assign out_valid    = lane_v[N_STAGES];
  assign out_data     = lane_d[N_STAGES];
  assign mode_shallow = shallow;

  // Edges since reset, saturating, so that $past never reaches before reset
  logic [3:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 4'd8) warm_q <= warm_q + 4'd1;
  end

  // R3: a deep-depth input shows up LAT_DEEP edges later
  a_r3_deep_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 4'd8 && $past(in_valid, LAT_DEEP) && !$past(shallow, LAT_DEEP)) |-> out_valid);

  // R4: a shallow-depth input shows up LAT_SHALLOW edges later
  a_r4_shallow_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 4'd8 && $past(in_valid, LAT_SHALLOW) && $past(shallow, LAT_SHALLOW)) |-> out_valid);

  // R8: every result traces back to a real input at the matching depth
  a_r8_no_phantom: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 4'd8 && out_valid) |->
      (shallow ? $past(in_valid, LAT_SHALLOW) : $past(in_valid, LAT_DEEP)));
endmodule

// File: tb/rdp_pipe_test.sv
`timescale 1ns/1ps
module rdp_pipe_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;
  logic        busy;
  logic        mode_shallow;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rdp_pipe uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data),
    .busy(busy), .mode_shallow(mode_shallow)
  );

  function automatic logic [15:0] expect_fn(input logic [15:0] x);
    logic [15:0] t;
    t = x + 16'h3A5C;
    t = t ^ 16'hC3A5;
    t = {t[14:0], t[15]};
    return t + 16'h1234;
  endfunction

  typedef struct { int due; logic [15:0] val; } item_t;
  item_t q[$];
  int    cyc = 0;
  int    last_due = -10;
  logic  m_shallow = 1'b0;
  logic  exp_v = 1'b0;
  logic [15:0] exp_d = '0;

  // Reference model: one update per rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; last_due = -10; m_shallow = 1'b0; exp_v = 1'b0; q.delete();
    end else begin
      item_t it;
      cyc = cyc + 1;
      if (mode_sel != m_shallow && !in_valid && last_due < cyc - 1) begin
        m_shallow = mode_sel;
      end else if (in_valid) begin
        it.due = cyc + (m_shallow ? 2 : 4) - 1;
        it.val = expect_fn(in_data);
        last_due = it.due;
        q.push_back(it);
      end
      exp_v = 1'b0;
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_v = 1'b1;
        exp_d = q[0].val;
        void'(q.pop_front());
      end
    end
  end

  task automatic check_bit(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s cycle %0d: actual=%0b expected=%0b", req, cyc, act, expv);
    end
  endtask

  task automatic compare_all();
    string lat_tag;
    lat_tag = m_shallow ? "R4 R5" : "R3 R5";
    if (exp_v) check_bit(lat_tag, out_valid, 1'b1);
    else       check_bit("R8", out_valid, 1'b0);
    if (exp_v && out_valid === 1'b1) begin
      checks++;
      if (out_data !== exp_d) begin
        errors++;
        $display("FAIL R2 cycle %0d: actual=%h expected=%h", cyc, out_data, exp_d);
      end
    end
    check_bit("R7", busy, mode_sel != m_shallow);
    check_bit("R6", mode_shallow, m_shallow);
  endtask

  task automatic tick(input logic v, input logic [15:0] d, input logic ms);
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_data  = d;
    mode_sel = ms;
  endtask

  task automatic idle(input int n, input logic ms);
    for (int i = 0; i < n; i++) tick(1'b0, 16'h0, ms);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    logic [15:0] corners [0:5];
    corners[0] = 16'h0000; corners[1] = 16'hFFFF; corners[2] = 16'h8000;
    corners[3] = 16'h0001; corners[4] = 16'h7FFF; corners[5] = 16'hC5A3;

    // R1: reset state
    repeat (3) @(negedge clk);
    check_bit("R1", out_valid, 1'b0);
    check_bit("R1", busy, 1'b0);
    check_bit("R1", mode_shallow, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    check_bit("R1", out_valid, 1'b0);
    check_bit("R1", mode_shallow, 1'b0);

    // R3 R5: back-to-back stream in deep depth
    for (int i = 0; i < 20; i++) tick(1'b1, 16'(i * 16'h1111 + 7), 1'b0);
    idle(6, 1'b0);
    // R8: gaps in deep depth
    for (int i = 0; i < 16; i++) tick(i[0], 16'(i * 16'h0F3 + 16'h100), 1'b0);
    // R6 R7: ask for shallow while words are in flight and still arriving
    for (int i = 0; i < 5; i++) tick(1'b1, 16'(16'hA000 + i), 1'b1);
    idle(8, 1'b1);
    // R4 R2: corner words in shallow depth
    for (int i = 0; i < 6; i++) tick(1'b1, corners[i], 1'b1);
    for (int i = 0; i < 12; i++) tick(1'b1, 16'(i * 16'h2345), 1'b1);
    idle(4, 1'b1);
    // R6: request deep while input keeps arriving on a drained chain
    for (int i = 0; i < 6; i++) tick(1'b1, 16'(16'h5000 + i), 1'b0);
    idle(8, 1'b0);
    // R2 R3: the same corner words in deep depth
    for (int i = 0; i < 6; i++) tick(1'b1, corners[i], 1'b0);
    idle(6, 1'b0);
    // R8 R5: long pseudo-random stream with depth toggles
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      tick(lfsr[3] | lfsr[7], lfsr, (i / 75) % 2 == 1);
    end
    idle(10, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule